// File: doc/BRIEF.md
# Pseudo-Random RAM Self-Test Engine

This engine exercises an attached single-port RAM with a repeatable pseudo-random sequence and decides pass or fail from one compacted signature. Three linear feedback shift registers supply the stimulus. One gives addresses, one gives write data, and an 8-bit one picks between read and write. All values that come back from reads go into a multiple-input signature register. After the final operation the engine raises `done`, and `pass` reports whether that signature equals the reference presented on `ref_sig`.

Two modes are available. In random mode the whole array is first set to all ones, and then `op_count` operations follow, each at a pseudo-random address. Each operation is a write of pseudo-random data or a read, chosen by comparing the operation field with a programmable threshold. In sweep mode addresses run in ascending order: a fill with pseudo-random data, then `op_count` passes of read-then-rewrite on every word, then a final read pass. The seeds and settings are captured at start, so a rerun with the same inputs reproduces the same stimulus exactly.

Requests to the RAM use a valid/ready handshake. A request is issued with `mem_valid` and counts only in a cycle where `mem_ready` is also high. While the RAM withholds `mem_ready`, the engine keeps the address, write enable and write data unchanged, so back-pressure only stretches the run. For an accepted read, the RAM returns its word on `mem_rdata` in the next cycle.

Top module: `rand_mem_tester`

## Requirements
- R1: While reset is low and after its release, `done`, `pass` and `mem_valid` are low until a run is started.
- R2: `start` is taken only when the engine is idle or done, and it clears `done`. A `start` while requests are being issued is ignored and does not change the run in progress.
- R3: When `mem_valid` is high and `mem_ready` is low, the next cycle still has `mem_valid` high with the same address, write enable and write data. Only accepted requests advance the test.
- R4: In random mode (`mode` = 0) the engine first writes the all-ones word to addresses 0 to 2^AW-1 in ascending order.
- R5: Random mode then performs `op_count` operations. Each uses the address LFSR's low AW bits as the address. It writes when the 8-bit operation LFSR state is below `wr_thresh` and reads otherwise. A write stores the data LFSR's low DW bits and steps the data LFSR. The address and operation LFSRs step after every accepted operation.
- R6: In sweep mode (`mode` = 1) the engine writes data-LFSR words to every address in ascending order. It then runs `op_count` passes in which each address is read and then rewritten with the next data word. It ends with one read pass over all addresses.
- R7: The address and data LFSRs are right-shifting Galois registers with feedback mask 0xB400. The operation LFSR uses mask 0xB8. An all-zero seed loads as 1. The operation seed is `addr_seed[15:8] ^ data_seed[7:0]`.
- R8: The signature is cleared at start. For each accepted read, in the cycle after acceptance, it becomes `{sig << 1} ^ (sig[MSB] ? 0x1D : 0) ^ mem_rdata`.
- R9: `done` rises once the last operation has been accepted and its read data folded in. It stays high with `mem_valid` low until the next start. `pass` is high exactly when `done` is high and the signature equals `ref_sig`.
- R10: With `op_count` = 0, random mode ends after its all-ones fill, and sweep mode runs its fill followed directly by the final read pass.
- R11: Two runs with identical inputs produce identical stimulus and the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (idle or done only) |
| mode | input | 1 | 0 random address/operation, 1 ascending sweep |
| addr_seed | input | LW | Address LFSR seed |
| data_seed | input | LW | Data LFSR seed |
| wr_thresh | input | 8 | Write when operation field is below this |
| op_count | input | CW | Operation count (random) or pass count (sweep) |
| ref_sig | input | DW | Reference signature compared at the end |
| mem_valid | output | 1 | RAM request valid |
| mem_ready | input | 1 | RAM accepts request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after read acceptance |
| done | output | 1 | Run finished |
| pass | output | 1 | Signature matched reference |

## Verification
The assertions assume that the RAM keeps to its side of the handshake: read data is valid exactly one cycle after a read is accepted, and `mem_ready` is a clean level. The bench's RAM model drives `mem_ready` either constantly high or from its own pseudo-random stall pattern, and it always returns read data at the fixed latency. The assertions also assume that `start` is a one-cycle pulse with settings held during it. The bench raises start and the settings together at a falling edge and drops start one cycle later.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_RAND, ST_SWEEP, ST_FINAL, ST_FLUSH, ST_DONE
  } rmt_state_e;

  localparam int OPW = 8;
  localparam logic [OPW-1:0] OP_POLY = 8'hB8;
  localparam logic MODE_RAND  = 1'b0;
  localparam logic MODE_SWEEP = 1'b1;
endpackage

// File: rtl/rmt_lfsr.sv
module rmt_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] POLY = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] nxt;
  assign nxt = state[0] ? ((state >> 1) ^ POLY) : (state >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     state <= ONE;
    else if (load)  state <= (seed == '0) ? ONE : seed;
    else if (step)  state <= nxt;
  end

  // R7: a maximal-length register never reaches the all-zero lock-up state
  p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/rmt_misr.sv
module rmt_misr #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] shifted;
  assign shifted = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)   sig <= '0;
    else if (clr) sig <= '0;
    else if (en)  sig <= shifted ^ din;
  end
endmodule

// File: rtl/rmt_ctrl.sv
module rmt_ctrl
  import rmt_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode,
  input  logic [CW-1:0]  op_count,
  input  logic [OPW-1:0] wr_thresh,
  input  logic [AW-1:0]  rnd_addr,
  input  logic [DW-1:0]  rnd_data,
  input  logic [OPW-1:0] op_field,
  input  logic           mem_ready,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           seed_load,
  output logic           addr_step,
  output logic           data_step,
  output logic           op_step,
  output logic           fold_en,
  output logic           done
);
  localparam logic [AW-1:0] LAST_ADDR = '1;

  rmt_state_e     state;
  logic [AW-1:0]  acnt;
  logic [CW-1:0]  ocnt;
  logic [CW-1:0]  t_q;
  logic [OPW-1:0] th_q;
  logic           mode_q;
  logic           rw_ph;
  logic           fire;
  logic           ocnt_last;

  assign seed_load = start && (state == ST_IDLE || state == ST_DONE);
  assign done      = (state == ST_DONE);
  assign fire      = mem_valid && mem_ready;
  assign ocnt_last = ((ocnt + 1'b1) == t_q);

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = acnt;
    mem_wdata = rnd_data;
    unique case (state)
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        if (mode_q == MODE_RAND) mem_wdata = '1;
      end
      ST_RAND: begin
        mem_valid = 1'b1;
        mem_we    = (op_field < th_q);
        mem_addr  = rnd_addr;
      end
      ST_SWEEP: begin
        mem_valid = 1'b1;
        mem_we    = rw_ph;
      end
      ST_FINAL: mem_valid = 1'b1;
      default: ;
    endcase
  end

  assign addr_step = fire && (state == ST_RAND);
  assign op_step   = fire && (state == ST_RAND);
  assign data_step = fire && mem_we && !(state == ST_FILL && mode_q == MODE_RAND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      acnt    <= '0;
      ocnt    <= '0;
      t_q     <= '0;
      th_q    <= '0;
      mode_q  <= MODE_RAND;
      rw_ph   <= 1'b0;
      fold_en <= 1'b0;
    end else begin
      fold_en <= fire && !mem_we;
      if (seed_load) begin
        state  <= ST_FILL;
        mode_q <= mode;
        t_q    <= op_count;
        th_q   <= wr_thresh;
        acnt   <= '0;
        ocnt   <= '0;
        rw_ph  <= 1'b0;
      end else begin
        unique case (state)
          ST_FILL: if (fire) begin
            acnt <= acnt + 1'b1;
            if (acnt == LAST_ADDR) begin
              if (mode_q == MODE_SWEEP) state <= (t_q == '0) ? ST_FINAL : ST_SWEEP;
              else                      state <= (t_q == '0) ? ST_FLUSH : ST_RAND;
            end
          end
          ST_RAND: if (fire) begin
            ocnt <= ocnt + 1'b1;
            if (ocnt_last) state <= ST_FLUSH;
          end
          ST_SWEEP: if (fire) begin
            rw_ph <= !rw_ph;
            if (rw_ph) begin
              acnt <= acnt + 1'b1;
              if (acnt == LAST_ADDR) begin
                ocnt <= ocnt + 1'b1;
                if (ocnt_last) state <= ST_FINAL;
              end
            end
          end
          ST_FINAL: if (fire) begin
            acnt <= acnt + 1'b1;
            if (acnt == LAST_ADDR) state <= ST_FLUSH;
          end
          ST_FLUSH: state <= ST_DONE;
          default: ;
        endcase
      end
    end
  end

  // R3: a stalled request is held unchanged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R9: no traffic once finished
  p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_valid);
  // R2: start during a run does not finish or restart it
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && start |=> !done);
  // R6: each sweep read is followed by a write to the same word
  p_rd_then_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWEEP) && fire && !mem_we |=> mem_valid && mem_we && (mem_addr == $past(mem_addr)));
endmodule

// File: rtl/rand_mem_tester.sv
module rand_mem_tester
  import rmt_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int LW = 16,
  parameter logic [LW-1:0] RND_POLY = 16'hB400,
  parameter logic [DW-1:0] SIG_POLY = 8'h1D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [LW-1:0] addr_seed,
  input  logic [LW-1:0] data_seed,
  input  logic [7:0]    wr_thresh,
  input  logic [CW-1:0] op_count,
  input  logic [DW-1:0] ref_sig,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          pass
);
  logic [LW-1:0]  a_state, d_state;
  logic [OPW-1:0] o_state, o_seed;
  logic [DW-1:0]  sig;
  logic seed_load, addr_step, data_step, op_step, fold_en;

  assign o_seed = addr_seed[LW-1 -: OPW] ^ data_seed[OPW-1:0];

  rmt_lfsr #(.W(LW), .POLY(RND_POLY)) u_addr_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(addr_seed),
    .step(addr_step), .state(a_state));

  rmt_lfsr #(.W(LW), .POLY(RND_POLY)) u_data_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(data_seed),
    .step(data_step), .state(d_state));

  rmt_lfsr #(.W(OPW), .POLY(OP_POLY)) u_op_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(o_seed),
    .step(op_step), .state(o_state));

  rmt_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .op_count(op_count), .wr_thresh(wr_thresh),
    .rnd_addr(a_state[AW-1:0]), .rnd_data(d_state[DW-1:0]), .op_field(o_state),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .seed_load(seed_load),
    .addr_step(addr_step), .data_step(data_step), .op_step(op_step),
    .fold_en(fold_en), .done(done));

  rmt_misr #(.W(DW), .POLY(SIG_POLY)) u_sig (
    .clk(clk), .rst_n(rst_n), .clr(seed_load), .en(fold_en),
    .din(mem_rdata), .sig(sig));

  assign pass = done && (sig == ref_sig);

  // R9: a pass verdict only exists at the end of a run
  p_pass_done_r9: assert property (@(posedge clk) disable iff (!rst_n) pass |-> done);
  // R8: the signature only moves on a start or a folded read
  p_sig_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sig) |-> $past(seed_load) || $past(fold_en));
endmodule

// File: tb/rand_mem_tester_test.sv
module rand_mem_tester_test;
  localparam int N = 16;

  typedef struct packed {
    logic        mode;
    logic [15:0] aseed;
    logic [15:0] dseed;
    logic [7:0]  th;
    logic [15:0] t;
    logic        stall;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 16'hACE1, 16'h1234, 8'd128, 16'd40,  1'b0},
    '{1'b0, 16'hACE1, 16'h1234, 8'd0,   16'd20,  1'b1},
    '{1'b0, 16'h0000, 16'h0000, 8'd200, 16'd30,  1'b1},
    '{1'b0, 16'h5A5A, 16'hFFFF, 8'd255, 16'd0,   1'b0},
    '{1'b1, 16'h0001, 16'hBEEF, 8'd9,   16'd2,   1'b0},
    '{1'b1, 16'h3333, 16'h0000, 8'd0,   16'd0,   1'b1},
    '{1'b1, 16'h7777, 16'hC0DE, 8'd77,  16'd3,   1'b1},
    '{1'b0, 16'h9999, 16'h4242, 8'd64,  16'd100, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [15:0] addr_seed = '0, data_seed = '0, op_count = '0;
  logic [7:0]  wr_thresh = '0, ref_sig = '0;
  logic mem_valid, mem_we, done, pass;
  logic mem_ready = 1'b1;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  logic [7:0]  bmem [N];
  logic [7:0]  emem [N];
  logic [15:0] stall_lfsr = 16'h1;
  logic        stall_en = 1'b0, cnt_clr = 1'b0, fault_on = 1'b0;
  int          nfire = 0;
  int          checks = 0, fails = 0;
  logic [7:0]  exp_sig;
  int          exp_ops;

  always #10 clk = !clk;

  rand_mem_tester uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .addr_seed(addr_seed), .data_seed(data_seed), .wr_thresh(wr_thresh),
    .op_count(op_count), .ref_sig(ref_sig), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .pass(pass));

  // RAM model: one-cycle read latency, optional stalls, optional bit-0 fault at word 5
  always @(posedge clk) begin
    stall_lfsr <= {stall_lfsr[14:0], stall_lfsr[15] ^ stall_lfsr[13] ^ stall_lfsr[12] ^ stall_lfsr[10]};
    mem_ready  <= stall_en ? stall_lfsr[0] : 1'b1;
    if (cnt_clr) nfire <= 0;
    else if (mem_valid && mem_ready) nfire <= nfire + 1;
    if (mem_valid && mem_ready) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else mem_rdata <= bmem[mem_addr] ^ ((fault_on && mem_addr == 4'd5) ? 8'h01 : 8'h00);
    end
  end

  function automatic logic [15:0] nx16(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction
  function automatic logic [7:0] nx8(input logic [7:0] s);
    return s[0] ? ((s >> 1) ^ 8'hB8) : (s >> 1);
  endfunction
  function automatic logic [7:0] fold8(input logic [7:0] s, input logic [7:0] d);
    return ({s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00)) ^ d;
  endfunction

  // Reference model of the whole run, written from R4..R8 and R10
  task automatic model(input vec_t v);
    logic [15:0] a, d;
    logic [7:0]  o, s;
    logic [3:0]  ad;
    a = (v.aseed == 0) ? 16'h1 : v.aseed;
    d = (v.dseed == 0) ? 16'h1 : v.dseed;
    o = v.aseed[15:8] ^ v.dseed[7:0];
    if (o == 0) o = 8'h1;
    s = '0;
    if (!v.mode) begin
      for (int i = 0; i < N; i++) emem[i] = 8'hFF;
      for (int k = 0; k < int'(v.t); k++) begin
        ad = a[3:0];
        if (o < v.th) begin emem[ad] = d[7:0]; d = nx16(d); end
        else s = fold8(s, emem[ad]);
        a = nx16(a); o = nx8(o);
      end
      exp_ops = N + int'(v.t);
    end else begin
      for (int i = 0; i < N; i++) begin emem[i] = d[7:0]; d = nx16(d); end
      for (int p = 0; p < int'(v.t); p++)
        for (int i = 0; i < N; i++) begin
          s = fold8(s, emem[i]); emem[i] = d[7:0]; d = nx16(d);
        end
      for (int i = 0; i < N; i++) s = fold8(s, emem[i]);
      exp_ops = 2 * N + 2 * N * int'(v.t);
    end
    exp_sig = s;
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    mode = v.mode; addr_seed = v.aseed; data_seed = v.dseed;
    wr_thresh = v.th; op_count = v.t; stall_en = v.stall;
    start = 1'b1; cnt_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_and_check(input vec_t v, input string req, input logic expect_pass);
    logic ok;
    model(v);
    launch(v);
    wait_done(ok);
    check(ok, req, "watchdog: done seen", int'(ok), 1);
    if (ok) begin
      ref_sig = exp_sig;
      #1;
      check(pass == expect_pass, req, "pass with model signature", int'(pass), int'(expect_pass));
      if (expect_pass) begin
        check(nfire == exp_ops, req, "accepted operations", nfire, exp_ops);
        begin
          int bad = 0;
          for (int i = 0; i < N; i++) if (bmem[i] !== emem[i]) bad++;
          check(bad == 0, req, "final RAM words differing", bad, 0);
        end
        ref_sig = exp_sig ^ 8'h01;
        #1;
        check(pass == 1'b0, "R9", "pass with wrong reference", int'(pass), 0);
      end
    end
  endtask

  initial begin
    #(20 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    // R1: reset state, even with a reference equal to the cleared signature
    ref_sig = 8'h00;
    #1;
    check(!done && !pass && !mem_valid, "R1", "outputs in reset", int'({done, pass, mem_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !pass && !mem_valid, "R1", "outputs after reset", int'({done, pass, mem_valid}), 0);

    // Table walk: R3 stalls, R4/R5 random mode, R6 sweep, R7 zero seeds, R10 zero count
    foreach (VECS[i]) begin
      string r;
      r = VECS[i].mode ? "R6" : "R5";
      if (VECS[i].t == 0) r = "R10";
      if (VECS[i].aseed == 0) r = "R7";
      if (VECS[i].stall) r = {r, "/R3"};
      run_and_check(VECS[i], r, 1'b1);
    end

    // R4: an all-read random run leaves the all-ones fill in place
    run_and_check(VECS[1], "R4", 1'b1);
    begin
      int ones = 0;
      for (int i = 0; i < N; i++) if (bmem[i] == 8'hFF) ones++;
      check(ones == N, "R4", "words holding all ones", ones, N);
    end

    // R9: done holds and the port stays quiet
    repeat (5) @(negedge clk);
    check(done && !mem_valid, "R9", "done held, no requests", int'({done, mem_valid}), 2);

    // R2: a start pulse mid-run is ignored
    model(VECS[7]);
    launch(VECS[7]);
    repeat (20) @(negedge clk);
    check(!done, "R2", "still running", int'(done), 0);
    addr_seed = 16'h1111; data_seed = 16'h2222; op_count = 16'd3; mode = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    ref_sig = exp_sig;
    #1;
    check(ok && pass, "R2", "original run unchanged", int'(pass), 1);
    check(nfire == exp_ops, "R2", "operation count of original run", nfire, exp_ops);

    // R8: a corrupted read changes the signature
    fault_on = 1'b1;
    run_and_check(VECS[6], "R8", 1'b0);
    fault_on = 1'b0;

    // R11: identical inputs give an identical signature
    run_and_check(VECS[4], "R11", 1'b1);
    run_and_check(VECS[4], "R11", 1'b1);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule